// File: doc/BRIEF.md
# Condition-Flag Data-Processing ALU

This block is the integer data-processing unit of a 32-bit RISC datapath. It takes a four-bit operation code, a first operand and a second operand, and returns the computed value, a flag saying whether that value is to be written back, and the next values of the four condition flags (negative, zero, carry, overflow). The second operand comes either from a register path, already shifted upstream, or from an immediate that the block builds itself by rotating an 8-bit constant.

Sixteen operations share one adder and one logic unit. The subtracting forms, including the ones with reversed operands, are built by inverting one adder input. The carry-consuming forms take the current carry flag as carry-in, so a subtract with carry removes the inverted carry. Four of the codes are compare/test forms. They compute a value only to set the flags, never request a write, and always update the flags, whatever the set-flags request says.

The unit is purely combinational. Predication, the register-operand barrel shifter and status-register moves sit outside it.

Top module: `dpu_alu`

## Requirements
- R1: Codes 4 (add), 2 (subtract, first minus second) and 3 (reverse subtract, second minus first) return the 32-bit wrapped result of that arithmetic.
- R2: Codes 0 (AND), 1 (XOR), 12 (OR), 13 (pass second), 14 (first AND NOT second) and 15 (NOT second) return the bitwise result.
- R3: `wrEn` is 0 for codes 8 (AND test), 9 (XOR test), 10 (subtract compare) and 11 (add compare), and 1 for every other code. The test and compare codes still compute their internal value from the first and second operands.
- R4: When `immSel` is 1, the second operand is `immByte` zero-extended to 32 bits and rotated right by twice `immRot`. When `immSel` is 0, the second operand is `regOpnd`.
- R5: When the flags update, N (`flagsOut[3]`) equals result bit 31, and Z (`flagsOut[2]`) is 1 exactly when the 32-bit result is zero.
- R6: When the flags update, C (`flagsOut[1]`) of an arithmetic code is the carry out of bit 31 for additions. For subtractions it is NOT borrow, so it is 1 when the unsigned minuend is at least the subtrahend plus any borrow-in.
- R7: When the flags update, V (`flagsOut[0]`) of an arithmetic code is 1 exactly when the signed two's-complement result overflows 32 bits.
- R8: When the flags update on a logical code, V keeps `flagsIn[0]`. C takes one of three values: `shiftCarry` for a register operand, bit 31 of the expanded immediate when `immRot` is nonzero, and `flagsIn[1]` when the immediate rotation is zero.
- R9: The flags update when `setFlags` is 1 or the code is 8 to 11. Otherwise `flagsOut` equals `flagsIn`.
- R10: Code 5 adds `flagsIn[1]`. Codes 6 (first minus second) and 7 (second minus first) subtract NOT `flagsIn[1]`. Their C and V follow R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation code 0..15 |
| opndA | input | 32 | First operand |
| regOpnd | input | 32 | Register-path second operand |
| immSel | input | 1 | 1 selects the rotated immediate as second operand |
| immByte | input | 8 | Immediate constant |
| immRot | input | 4 | Immediate rotation, in steps of two bits |
| shiftCarry | input | 1 | Carry produced by the external register shifter |
| setFlags | input | 1 | Request to update flags on non-compare codes |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| wrEn | output | 1 | Result write-back request |
| flagsOut | output | 4 | Next flags {N,Z,C,V} |

## Verification
No register lies between the inputs and the outputs, so `result`, `wrEn` and `flagsOut` are all due in the same cycle the operands are applied, with zero cycles of latency. Each scenario task changes the inputs just after a falling clock edge, waits a short fixed delay for the logic to settle, and samples all three outputs before the next rising edge. The expected values come from a reference function that uses 64-bit unsigned and signed arithmetic rather than the design's inverted-operand adder.

// File: rtl/dpu_alu_pkg.sv
package dpu_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    LG_AND, LG_EOR, LG_ORR, LG_BIC, LG_MOV, LG_MVN
  } logicSel_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_FLAG
  } carrySrc_e;

  typedef struct packed {
    logic      useAdder;
    logic      invA;
    logic      invB;
    carrySrc_e carrySrc;
    logicSel_e logicSel;
    logic      writeEn;
    logic      flagUpd;
  } aluCtrl_t;

  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/dpu_alu_ctrl.sv
module dpu_alu_ctrl
  import dpu_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       setFlags,
  output aluCtrl_t   strobes
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    strobes          = '0;
    strobes.carrySrc = CI_ZERO;
    strobes.logicSel = LG_AND;
    strobes.writeEn  = 1'b1;
    unique case (op)
      OP_AND: strobes.logicSel = LG_AND;
      OP_EOR: strobes.logicSel = LG_EOR;
      OP_SUB: begin
        strobes.useAdder = 1'b1; strobes.invB = 1'b1; strobes.carrySrc = CI_ONE;
      end
      OP_RSB: begin
        strobes.useAdder = 1'b1; strobes.invA = 1'b1; strobes.carrySrc = CI_ONE;
      end
      OP_ADD: strobes.useAdder = 1'b1;
      OP_ADC: begin
        strobes.useAdder = 1'b1; strobes.carrySrc = CI_FLAG;
      end
      OP_SBC: begin
        strobes.useAdder = 1'b1; strobes.invB = 1'b1; strobes.carrySrc = CI_FLAG;
      end
      OP_RSC: begin
        strobes.useAdder = 1'b1; strobes.invA = 1'b1; strobes.carrySrc = CI_FLAG;
      end
      OP_TST: begin
        strobes.logicSel = LG_AND; strobes.writeEn = 1'b0;
      end
      OP_TEQ: begin
        strobes.logicSel = LG_EOR; strobes.writeEn = 1'b0;
      end
      OP_CMP: begin
        strobes.useAdder = 1'b1; strobes.invB = 1'b1; strobes.carrySrc = CI_ONE;
        strobes.writeEn  = 1'b0;
      end
      OP_CMN: begin
        strobes.useAdder = 1'b1; strobes.writeEn = 1'b0;
      end
      OP_ORR: strobes.logicSel = LG_ORR;
      OP_MOV: strobes.logicSel = LG_MOV;
      OP_BIC: strobes.logicSel = LG_BIC;
      OP_MVN: strobes.logicSel = LG_MVN;
      default: strobes.logicSel = LG_AND;
    endcase
    strobes.flagUpd = setFlags | ~strobes.writeEn;
  end

  // A subtracting code never takes both operands inverted.
  always_comb begin
    AST_SINGLE_INVERT: assert (!(strobes.invA && strobes.invB)); // R1
  end

endmodule

// File: rtl/dpu_alu_datapath.sv
module dpu_alu_datapath
  import dpu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  aluCtrl_t              strobes,
  input  logic [DATA_W-1:0]     opndA,
  input  logic [DATA_W-1:0]     regOpnd,
  input  logic                  immSel,
  input  logic [IMM_W-1:0]      immByte,
  input  logic [ROT_W-1:0]      immRot,
  input  logic                  shiftCarry,
  input  logic [FLAG_W-1:0]     flagsIn,
  output logic [DATA_W-1:0]     result,
  output logic [FLAG_W-1:0]     flagsOut
);

  localparam int MSB   = DATA_W - 1;
  localparam int AMT_W = ROT_W + 1;

  logic [AMT_W-1:0]  rotAmt;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] immRotd;
  logic              immCarry;
  logic [DATA_W-1:0] opB;
  logic              logicCarry;

  assign rotAmt = {immRot, 1'b0};
  assign immExt = {{(DATA_W-IMM_W){1'b0}}, immByte};

  generate
    for (genvar g = 0; g < DATA_W; g++) begin : gRot
      always_comb begin
        immRotd[g] = immExt[(g + int'(rotAmt)) % DATA_W];
      end
    end
  endgenerate

  assign immCarry   = (rotAmt == '0) ? flagsIn[FLAG_C] : immRotd[MSB];
  assign opB        = immSel ? immRotd : regOpnd;
  assign logicCarry = immSel ? immCarry : shiftCarry;

  // Shared adder
  logic [DATA_W-1:0] addX, addY;
  logic              carryBit;
  logic [DATA_W:0]   sumW;
  logic              arithV;

  assign addX = strobes.invA ? ~opndA : opndA;
  assign addY = strobes.invB ? ~opB   : opB;

  always_comb begin
    unique case (strobes.carrySrc)
      CI_ONE:  carryBit = 1'b1;
      CI_FLAG: carryBit = flagsIn[FLAG_C];
      default: carryBit = 1'b0;
    endcase
  end

  assign sumW   = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, carryBit};
  assign arithV = (addX[MSB] == addY[MSB]) && (sumW[MSB] != addX[MSB]);

  // Logic unit
  logic [DATA_W-1:0] logicRes;

  always_comb begin
    unique case (strobes.logicSel)
      LG_EOR:  logicRes = opndA ^ opB;
      LG_ORR:  logicRes = opndA | opB;
      LG_BIC:  logicRes = opndA & ~opB;
      LG_MOV:  logicRes = opB;
      LG_MVN:  logicRes = ~opB;
      default: logicRes = opndA & opB;
    endcase
  end

  assign result = strobes.useAdder ? sumW[MSB:0] : logicRes;

  always_comb begin
    flagsOut = flagsIn;
    if (strobes.flagUpd) begin
      flagsOut[FLAG_N] = result[MSB];
      flagsOut[FLAG_Z] = ~|result;
      flagsOut[FLAG_C] = strobes.useAdder ? sumW[DATA_W] : logicCarry;
      flagsOut[FLAG_V] = strobes.useAdder ? arithV : flagsIn[FLAG_V];
    end
  end

  // Assertions next to the logic they guard
  always_comb begin
    if (!strobes.flagUpd)
      AST_FLAGS_HOLD: assert (flagsOut == flagsIn); // R9
    if (strobes.flagUpd && !strobes.useAdder)
      AST_LOGIC_V_KEEP: assert (flagsOut[FLAG_V] == flagsIn[FLAG_V]); // R8
    if (immSel && immRot == '0)
      AST_IMM_ROT0: assert (opB == DATA_W'(immByte)); // R4
    if (strobes.flagUpd && strobes.useAdder && strobes.invB && strobes.carrySrc == CI_ONE)
      AST_SUB_CARRY: assert (flagsOut[FLAG_C] == (opndA >= opB)); // R6
    if (strobes.flagUpd && strobes.useAdder && !strobes.invA && !strobes.invB
        && strobes.carrySrc == CI_ZERO)
      AST_ADD_CARRY: assert (flagsOut[FLAG_C] == ((DATA_W+1)'(opndA) + (DATA_W+1)'(opB) > (DATA_W+1)'({DATA_W{1'b1}}))); // R6
  end

endmodule

// File: rtl/dpu_alu.sv
module dpu_alu
  import dpu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opndA,
  input  logic [DATA_W-1:0] regOpnd,
  input  logic              immSel,
  input  logic [IMM_W-1:0]  immByte,
  input  logic [ROT_W-1:0]  immRot,
  input  logic              shiftCarry,
  input  logic              setFlags,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic [3:0]        flagsOut
);

  aluCtrl_t strobes;

  dpu_alu_ctrl uCtrl (
    .opCode   (opCode),
    .setFlags (setFlags),
    .strobes  (strobes)
  );

  dpu_alu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) uDp (
    .strobes    (strobes),
    .opndA      (opndA),
    .regOpnd    (regOpnd),
    .immSel     (immSel),
    .immByte    (immByte),
    .immRot     (immRot),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .result     (result),
    .flagsOut   (flagsOut)
  );

  assign wrEn = strobes.writeEn;

  always_comb begin
    if (opCode[3:2] == 2'b10)
      AST_CMP_NO_WRITE: assert (!wrEn); // R3
    if (opCode == 4'd13 && !immSel)
      AST_MOV_PASS: assert (result == regOpnd); // R2
  end

endmodule

// File: tb/dpu_alu_test.sv
module dpu_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] opndA = '0;
  logic [31:0] regOpnd = '0;
  logic        immSel = 1'b0;
  logic [7:0]  immByte = '0;
  logic [3:0]  immRot = '0;
  logic        shiftCarry = 1'b0;
  logic        setFlags = 1'b0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] result;
  logic        wrEn;
  logic [3:0]  flagsOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dpu_alu uut (
    .opCode(opCode), .opndA(opndA), .regOpnd(regOpnd), .immSel(immSel),
    .immByte(immByte), .immRot(immRot), .shiftCarry(shiftCarry),
    .setFlags(setFlags), .flagsIn(flagsIn), .result(result), .wrEn(wrEn),
    .flagsOut(flagsOut)
  );

  function automatic logic [31:0] rotR(input logic [7:0] b, input logic [3:0] r);
    logic [31:0] v = {24'b0, b};
    int sh = 2 * int'(r);
    if (sh == 0) return v;
    return (v >> sh) | (v << (32 - sh));
  endfunction

  // Reference: returns {result, wrEn, flags}
  function automatic logic [36:0] refModel(
      input logic [3:0] op, input logic [31:0] a, input logic [31:0] rb,
      input logic isImm, input logic [7:0] ib, input logic [3:0] ir,
      input logic sc, input logic sf, input logic [3:0] fl);
    logic [31:0] b  = isImm ? rotR(ib, ir) : rb;
    logic        lc = isImm ? ((ir == 0) ? fl[1] : b[31]) : sc;
    logic [63:0] ua = {32'b0, a};
    logic [63:0] ub = {32'b0, b};
    longint      sa = longint'($signed(a));
    longint      sb = longint'($signed(b));
    longint      ci = longint'(fl[1]);
    longint      s  = 0;
    logic [63:0] r64 = '0;
    logic        c = 1'b0, arith = 1'b1, wr, upd, v;
    logic [31:0] res;
    logic [3:0]  fo;
    case (op)
      4'd4, 4'd11: begin r64 = ua + ub;          c = r64[32];        s = sa + sb; end
      4'd5:        begin r64 = ua + ub + 64'(ci); c = r64[32];       s = sa + sb + ci; end
      4'd2, 4'd10: begin r64 = ua - ub;          c = (ua >= ub);     s = sa - sb; end
      4'd6:        begin r64 = ua - ub - 64'(1 - ci); c = (ua >= ub + 64'(1 - ci)); s = sa - sb - (1 - ci); end
      4'd3:        begin r64 = ub - ua;          c = (ub >= ua);     s = sb - sa; end
      4'd7:        begin r64 = ub - ua - 64'(1 - ci); c = (ub >= ua + 64'(1 - ci)); s = sb - sa - (1 - ci); end
      4'd0, 4'd8:  begin arith = 1'b0; r64 = {32'b0, a & b}; end
      4'd1, 4'd9:  begin arith = 1'b0; r64 = {32'b0, a ^ b}; end
      4'd12:       begin arith = 1'b0; r64 = {32'b0, a | b}; end
      4'd13:       begin arith = 1'b0; r64 = {32'b0, b}; end
      4'd14:       begin arith = 1'b0; r64 = {32'b0, a & ~b}; end
      default:     begin arith = 1'b0; r64 = {32'b0, ~b}; end
    endcase
    res = r64[31:0];
    v   = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    wr  = !(op >= 4'd8 && op <= 4'd11);
    upd = sf || !wr;
    fo  = upd ? {res[31], res == 32'd0, arith ? c : lc, arith ? v : fl[0]} : fl;
    return {res, wr, fo};
  endfunction

  task automatic tryOp(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] rb, input logic isImm, input logic [7:0] ib,
                       input logic [3:0] ir, input logic sc, input logic sf,
                       input logic [3:0] fl);
    logic [36:0] exp;
    @(negedge clk);
    opCode = op; opndA = a; regOpnd = rb; immSel = isImm; immByte = ib;
    immRot = ir; shiftCarry = sc; setFlags = sf; flagsIn = fl;
    exp = refModel(op, a, rb, isImm, ib, ir, sc, sf, fl);
    #2;
    total++;
    if (result !== exp[36:5]) begin
      bad++;
      $display("FAIL %s op=%0d result act=%h exp=%h", tag, op, result, exp[36:5]);
    end
    total++;
    if (wrEn !== exp[4]) begin
      bad++;
      $display("FAIL %s op=%0d wrEn act=%b exp=%b", tag, op, wrEn, exp[4]);
    end
    total++;
    if (flagsOut !== exp[3:0]) begin
      bad++;
      $display("FAIL %s op=%0d flags act=%b exp=%b", tag, op, flagsOut, exp[3:0]);
    end
  endtask

  task automatic testReset();  // R9: quiet inputs after reset, flags pass through
    tryOp("R9 reset", 4'd0, 32'd0, 32'd0, 0, 8'd0, 4'd0, 0, 0, 4'b0000);
  endtask

  task automatic testArith();  // R1
    tryOp("R1 add", 4'd4, 32'd1234, 32'd4321, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R1 sub", 4'd2, 32'd10, 32'd3, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R1 rsb", 4'd3, 32'd10, 32'd3, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R1 wrap", 4'd4, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, 0, 0, 4'b0000);
  endtask

  task automatic testLogic();  // R2
    logic [31:0] x = 32'hF0F0_1234;
    logic [31:0] y = 32'h0FF0_FF00;
    tryOp("R2 and", 4'd0, x, y, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R2 eor", 4'd1, x, y, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R2 orr", 4'd12, x, y, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R2 mov", 4'd13, x, y, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R2 bic", 4'd14, x, y, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R2 mvn", 4'd15, x, y, 0, 0, 0, 0, 0, 4'b0000);
  endtask

  task automatic testCompare();  // R3
    tryOp("R3 tst", 4'd8, 32'h00FF, 32'hFF00, 0, 0, 0, 1, 0, 4'b0000);
    tryOp("R3 teq", 4'd9, 32'h5555, 32'h5555, 0, 0, 0, 0, 0, 4'b1001);
    tryOp("R3 cmp", 4'd10, 32'd5, 32'd7, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R3 cmn", 4'd11, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 0, 4'b0001);
  endtask

  task automatic testImm();  // R4
    tryOp("R4 rot0", 4'd13, 0, 32'hDEAD_BEEF, 1, 8'hA5, 4'd0, 0, 0, 4'b0000);
    tryOp("R4 rot1", 4'd13, 0, 0, 1, 8'hA5, 4'd1, 0, 0, 4'b0000);
    tryOp("R4 rot4", 4'd4, 32'd1, 0, 1, 8'h3F, 4'd4, 0, 0, 4'b0000);
    tryOp("R4 rot15", 4'd12, 32'h1, 0, 1, 8'hFF, 4'd15, 0, 0, 4'b0000);
  endtask

  task automatic testNZ();  // R5
    tryOp("R5 zero", 4'd2, 32'd77, 32'd77, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R5 neg", 4'd15, 0, 32'd0, 0, 0, 0, 0, 1, 4'b0100);
  endtask

  task automatic testCarry();  // R6
    tryOp("R6 addc", 4'd4, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R6 subnb", 4'd2, 32'd9, 32'd9, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R6 subb", 4'd2, 32'd3, 32'd9, 0, 0, 0, 0, 1, 4'b0010);
    tryOp("R6 rsbb", 4'd3, 32'd9, 32'd3, 0, 0, 0, 0, 1, 4'b0010);
  endtask

  task automatic testOverflow();  // R7
    tryOp("R7 addv", 4'd4, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R7 subv", 4'd2, 32'h8000_0000, 32'd1, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R7 subm", 4'd10, 32'd0, 32'h8000_0000, 0, 0, 0, 0, 0, 4'b0000);
    tryOp("R7 nov", 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 4'b0001);
  endtask

  task automatic testLogicFlags();  // R8
    tryOp("R8 shc", 4'd0, 32'hFF, 32'h0F, 0, 0, 0, 1, 1, 4'b0001);
    tryOp("R8 shc0", 4'd1, 32'hFF, 32'h0F, 0, 0, 0, 0, 1, 4'b0010);
    tryOp("R8 immc", 4'd13, 0, 0, 1, 8'h02, 4'd1, 0, 1, 4'b0000);
    tryOp("R8 immk", 4'd13, 0, 0, 1, 8'h80, 4'd0, 0, 1, 4'b0010);
    tryOp("R8 immk0", 4'd13, 0, 0, 1, 8'h80, 4'd0, 1, 1, 4'b0000);
  endtask

  task automatic testHold();  // R9
    tryOp("R9 hold", 4'd4, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 1, 0, 4'b0110);
    tryOp("R9 holdl", 4'd15, 0, 0, 0, 0, 0, 1, 0, 4'b1001);
  endtask

  task automatic testCarryIn();  // R10
    tryOp("R10 adc1", 4'd5, 32'd10, 32'd20, 0, 0, 0, 0, 1, 4'b0010);
    tryOp("R10 adc0", 4'd5, 32'hFFFF_FFFF, 32'd0, 0, 0, 0, 0, 1, 4'b0010);
    tryOp("R10 sbc0", 4'd6, 32'd10, 32'd3, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R10 sbc1", 4'd6, 32'd3, 32'd3, 0, 0, 0, 0, 1, 4'b0010);
    tryOp("R10 sbcb", 4'd6, 32'd3, 32'd3, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R10 rsc0", 4'd7, 32'd3, 32'd10, 0, 0, 0, 0, 1, 4'b0000);
    tryOp("R10 rsc1", 4'd7, 32'd3, 32'd10, 0, 0, 0, 0, 1, 4'b0010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testArith();
    testLogic();
    testCompare();
    testImm();
    testNZ();
    testCarry();
    testOverflow();
    testLogicFlags();
    testHold();
    testCarryIn();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule